// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block owns the current status word of a small processor core and one saved copy of it for each privileged mode. At every instruction boundary it looks at the pending exception sources (data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt), picks the most urgent one that is not masked, and performs the entry in a single clock edge. The entry banks the old status word into the saved register of the target mode, stores a return link into that mode's link register, rewrites the mode, state and mask bits, and tells the PC sequencer to load the exception's fixed vector.

The same unit runs the return operation. When a return completes, the saved status of the current mode is copied back into the status word and the mode's link value is driven to the PC sequencer. Reset is asynchronous. It forces supervisor mode with both interrupt masks set and redirects the PC to the reset vector. Reset saves no status word and cannot be returned from.

The PC sequencer provides the return link for each boundary, so offsets that differ between exception kinds stay outside this block. The load request and the target address are produced combinationally in the boundary cycle. The status word, the saved words and the link values change at the following clock edge.

Top module: `xcpt_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pc_load` is 1 and `pc_target` equals `VEC_BASE`. All other inputs are ignored in that time. The status word then reads 0xD3: mode 10011 (supervisor) in bits [4:0], state flag bit 5 clear, fast mask bit 6 set, normal mask bit 7 set, and upper bits zero.
- R2: At a boundary, the exception taken is the first unmasked source in this order: data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. `xcpt_taken` shows it one-hot, with bit 0 for data abort, 1 for fast, 2 for normal, 3 for prefetch abort, 4 for undefined and 5 for software interrupt.
- R3: On entry, `pc_load` is 1 and `pc_target` is `VEC_BASE` plus the vector offset: 0x10 for data abort, 0x1C for fast, 0x18 for normal, 0x0C for prefetch abort, 0x04 for undefined, 0x08 for software interrupt.
- R4: After entry, status bits [4:0] hold the target mode: 10111 for either abort, 10001 for fast, 10010 for normal, 11011 for undefined, 10011 for software interrupt. Bit 5 is clear and bit 7 is set.
- R5: Entry for a fast interrupt sets status bit 6. Every other exception leaves bit 6 as it was.
- R6: A normal interrupt request is not taken while status bit 7 is set. A fast interrupt request is not taken while status bit 6 is set.
- R7: Entry copies the status word that was in force into the saved register of the target mode. A later return from that mode restores exactly that word.
- R8: Entry stores `link_in` in the target mode's link register. A later return from that mode drives that value on `pc_target`.
- R9: A return (`ret_req` with `insn_done`) in a privileged mode drives `pc_load` 1 with `pc_target` equal to the mode's link value, and loads the mode's saved word into the status word.
- R10: A return while bits [4:0] hold user mode 10000 (or any code with no saved register) has no effect: `pc_load` stays 0 and the status word is unchanged.
- R11: Without `insn_done`, all requests are ignored. `pc_load` is 0, `xcpt_taken` is 0 and the status word holds.
- R12: When a return and an exception fall on the same boundary, the return completes first. The masks used, the word banked and the status word rewritten are the restored word, and the link stored is the return target. `pc_target` is the exception's vector.
- R13: At most one bit of `xcpt_taken` is set in any cycle, and `pc_load` is 1 whenever one is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; acts as the reset exception |
| insn_done | input | 1 | Current instruction completes this cycle (boundary) |
| ret_req | input | 1 | Completing instruction is an exception return |
| dabt_req | input | 1 | Data abort raised by the completing instruction |
| fiq_req | input | 1 | Fast interrupt request level |
| irq_req | input | 1 | Normal interrupt request level |
| pabt_req | input | 1 | Prefetch abort on the completing instruction |
| und_req | input | 1 | Undefined instruction (exclusive with swi_req) |
| swi_req | input | 1 | Software interrupt instruction (exclusive with und_req) |
| link_in | input | ADDR_W | Return link for an exception taken this cycle |
| pc_load | output | 1 | PC sequencer must load pc_target |
| pc_target | output | ADDR_W | Vector or return address |
| xcpt_taken | output | 6 | One-hot exception taken this cycle |
| cpsr | output | SR_W | Current status word |

## Verification
A return and an exception entry can complete on the same boundary. This is the case where the order of the two operations decides the result. The bench sets it up from normal-interrupt mode, where bit 6 is clear in the live word but the saved word returns to user mode. It asserts `ret_req` together with a fast interrupt request, and later repeats the case at random against a behavioural model that applies the return first. The case is judged correct when the vector is the fast one and the status rewrite starts from the restored word. A further return from fast mode must then yield the old normal-mode link and the user-mode word, which shows that the banked word and link came from the return.

// File: rtl/xcpt_pkg.sv
`timescale 1ns/1ps
package xcpt_pkg;
   localparam int NSRC    = 6;
   localparam int NBANK   = 5;
   localparam int BANK_IW = $clog2(NBANK);
   localparam int MODE_W  = 5;

   // status word bit positions decoded by neighbours
   localparam int SR_T = 5;
   localparam int SR_F = 6;
   localparam int SR_I = 7;

   typedef enum logic [MODE_W-1:0] {
      M_USR = 5'b10000,
      M_FIQ = 5'b10001,
      M_IRQ = 5'b10010,
      M_SVC = 5'b10011,
      M_ABT = 5'b10111,
      M_UND = 5'b11011
   } mode_e;

   // source index doubles as priority rank (0 = most urgent)
   localparam int S_DABT = 0;
   localparam int S_FIQ  = 1;
   localparam int S_IRQ  = 2;
   localparam int S_PABT = 3;
   localparam int S_UND  = 4;
   localparam int S_SWI  = 5;

   typedef struct packed {
      logic [MODE_W-1:0]  mode;
      logic [BANK_IW-1:0] bank;
      logic [4:0]         voff;
      logic               set_f;
   } src_info_t;

   typedef struct packed {
      logic               hit;
      logic [BANK_IW-1:0] idx;
   } bank_sel_t;

   function automatic src_info_t info_of(input int idx);
      src_info_t r;
      case (idx)
         S_DABT:  r = '{M_ABT, BANK_IW'(3), 5'h10, 1'b0};
         S_FIQ:   r = '{M_FIQ, BANK_IW'(0), 5'h1C, 1'b1};
         S_IRQ:   r = '{M_IRQ, BANK_IW'(1), 5'h18, 1'b0};
         S_PABT:  r = '{M_ABT, BANK_IW'(3), 5'h0C, 1'b0};
         S_UND:   r = '{M_UND, BANK_IW'(4), 5'h04, 1'b0};
         S_SWI:   r = '{M_SVC, BANK_IW'(2), 5'h08, 1'b0};
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic bank_sel_t bank_of(input logic [MODE_W-1:0] m);
      bank_sel_t r;
      case (m)
         M_FIQ:   r = '{1'b1, BANK_IW'(0)};
         M_IRQ:   r = '{1'b1, BANK_IW'(1)};
         M_SVC:   r = '{1'b1, BANK_IW'(2)};
         M_ABT:   r = '{1'b1, BANK_IW'(3)};
         M_UND:   r = '{1'b1, BANK_IW'(4)};
         default: r = '{1'b0, BANK_IW'(0)};
      endcase
      return r;
   endfunction
endpackage

// File: rtl/xcpt_arbiter.sv
`timescale 1ns/1ps
module xcpt_arbiter #(
   parameter int N = 6
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   if (N < 1) begin : g_n_chk
      $error("xcpt_arbiter: N must be at least 1");
   end

   // seen[i] is set when any higher-ranked source requests
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_rank
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N];
endmodule

// File: rtl/xcpt_bank.sv
`timescale 1ns/1ps
module xcpt_bank #(
   parameter int             W       = 32,
   parameter int             DEPTH   = 5,
   parameter int             IDX_W   = $clog2(DEPTH),
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [W-1:0]     rdata
);
   if (DEPTH < 2 || (1 << IDX_W) < DEPTH) begin : g_depth_chk
      $error("xcpt_bank: DEPTH/IDX_W inconsistent");
   end

   logic [W-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[g] <= RST_VAL;
         else if (we && widx == IDX_W'(g))
            slot[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++)
         if (ridx == IDX_W'(i))
            rdata = slot[i];
   end
endmodule

// File: rtl/xcpt_entry.sv
`timescale 1ns/1ps
module xcpt_entry
   import xcpt_pkg::*;
#(
   parameter int                SR_W     = 32,
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic [NSRC-1:0]    gnt,
   input  logic [SR_W-1:0]    base_sr,
   output logic [SR_W-1:0]    new_sr,
   output logic [ADDR_W-1:0]  vector,
   output logic [BANK_IW-1:0] bank
);
   src_info_t masked [NSRC];
   src_info_t sel;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign masked[g] = gnt[g] ? info_of(g) : '0;
   end

   always_comb begin
      sel = '0;
      for (int i = 0; i < NSRC; i++)
         sel = sel | masked[i];
   end

   always_comb begin
      new_sr             = base_sr;
      new_sr[MODE_W-1:0] = sel.mode;
      new_sr[SR_T]       = 1'b0;
      new_sr[SR_I]       = 1'b1;
      new_sr[SR_F]       = base_sr[SR_F] | sel.set_f;
   end

   assign vector = VEC_BASE + ADDR_W'(sel.voff);
   assign bank   = sel.bank;
endmodule

// File: rtl/xcpt_ctrl.sv
`timescale 1ns/1ps
module xcpt_ctrl
   import xcpt_pkg::*;
#(
   parameter int                SR_W     = 32,
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_done,
   input  logic              ret_req,
   input  logic              dabt_req,
   input  logic              fiq_req,
   input  logic              irq_req,
   input  logic              pabt_req,
   input  logic              und_req,
   input  logic              swi_req,
   input  logic [ADDR_W-1:0] link_in,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_target,
   output logic [NSRC-1:0]   xcpt_taken,
   output logic [SR_W-1:0]   cpsr
);
   if (SR_W < 8) begin : g_sr_chk
      $error("xcpt_ctrl: SR_W must hold mode, state and mask bits");
   end
   if (ADDR_W < 5) begin : g_addr_chk
      $error("xcpt_ctrl: ADDR_W too narrow for the vector table");
   end

   localparam logic [SR_W-1:0] SR_RESET    = {{(SR_W-8){1'b0}}, 1'b1, 1'b1, 1'b0, M_SVC};
   localparam logic [SR_W-1:0] SAVED_RESET = {{(SR_W-MODE_W){1'b0}}, M_USR};

   logic               rst_pend;
   logic [SR_W-1:0]    sr_q, sr_d;
   bank_sel_t          cur;
   logic [SR_W-1:0]    saved_cur;
   logic [ADDR_W-1:0]  link_cur;
   logic               boundary, ret_ok;
   logic [SR_W-1:0]    eff_sr;
   logic [NSRC-1:0]    raw_req, gnt;
   logic               any_x;
   logic [SR_W-1:0]    entry_sr;
   logic [ADDR_W-1:0]  entry_vec;
   logic [BANK_IW-1:0] tgt_bank;
   logic [ADDR_W-1:0]  link_wr;

   // reset entry: redirect during reset and the first cycle after it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_pend <= 1'b1;
      else        rst_pend <= 1'b0;
   end

   assign cur      = bank_of(sr_q[MODE_W-1:0]);
   assign boundary = insn_done & ~rst_pend;
   assign ret_ok   = boundary & ret_req & cur.hit;
   // the return retires first, so entry sees the restored word
   assign eff_sr   = ret_ok ? saved_cur : sr_q;

   assign raw_req[S_DABT] = dabt_req;
   assign raw_req[S_FIQ]  = fiq_req & ~eff_sr[SR_F];
   assign raw_req[S_IRQ]  = irq_req & ~eff_sr[SR_I];
   assign raw_req[S_PABT] = pabt_req;
   assign raw_req[S_UND]  = und_req;
   assign raw_req[S_SWI]  = swi_req;

   xcpt_arbiter #(.N(NSRC)) u_arb (
      .req (raw_req & {NSRC{boundary}}),
      .gnt (gnt),
      .any (any_x)
   );

   xcpt_entry #(.SR_W(SR_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_entry (
      .gnt     (gnt),
      .base_sr (eff_sr),
      .new_sr  (entry_sr),
      .vector  (entry_vec),
      .bank    (tgt_bank)
   );

   assign link_wr = ret_ok ? link_cur : link_in;

   xcpt_bank #(.W(SR_W), .DEPTH(NBANK), .IDX_W(BANK_IW), .RST_VAL(SAVED_RESET)) u_saved (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (any_x),
      .widx  (tgt_bank),
      .wdata (eff_sr),
      .ridx  (cur.idx),
      .rdata (saved_cur)
   );

   xcpt_bank #(.W(ADDR_W), .DEPTH(NBANK), .IDX_W(BANK_IW), .RST_VAL('0)) u_link (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (any_x),
      .widx  (tgt_bank),
      .wdata (link_wr),
      .ridx  (cur.idx),
      .rdata (link_cur)
   );

   always_comb begin
      if (any_x)       sr_d = entry_sr;
      else if (ret_ok) sr_d = saved_cur;
      else             sr_d = sr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= SR_RESET;
      else        sr_q <= sr_d;
   end

   assign pc_load    = rst_pend | any_x | ret_ok;
   assign pc_target  = rst_pend ? VEC_BASE : (any_x ? entry_vec : link_cur);
   assign xcpt_taken = gnt;
   assign cpsr       = sr_q;
endmodule

// File: rtl/xcpt_ctrl_chk.sv
`timescale 1ns/1ps
module xcpt_ctrl_chk #(
   parameter int                SR_W     = 32,
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_done,
   input logic              ret_req,
   input logic              pc_load,
   input logic [ADDR_W-1:0] pc_target,
   input logic [5:0]        xcpt_taken,
   input logic [SR_W-1:0]   cpsr
);
   logic started;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   p_reset_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> pc_load && pc_target == VEC_BASE && cpsr[7:0] == 8'hD3);

   p_taken_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xcpt_taken) && ((xcpt_taken != '0) -> pc_load));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      started && !insn_done |-> !pc_load && xcpt_taken == '0);

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      started && !insn_done |=> $stable(cpsr));

   p_fiq_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xcpt_taken[1] |-> pc_target == VEC_BASE + ADDR_W'(5'h1C));

   p_dabt_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xcpt_taken[0] |=> cpsr[4:0] == 5'b10111 && cpsr[7] && !cpsr[5]);

   p_fiq_sets_f_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xcpt_taken[1] |=> cpsr[6] && cpsr[7]);

   p_keep_f_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xcpt_taken[0] || xcpt_taken[5:2] != '0) && !ret_req |=> cpsr[6] == $past(cpsr[6]));

   p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xcpt_taken[2] && !ret_req |-> !cpsr[7]);

   p_fiq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xcpt_taken[1] && !ret_req |-> !cpsr[6]);
endmodule

bind xcpt_ctrl xcpt_ctrl_chk #(
   .SR_W(SR_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_done  (insn_done),
   .ret_req    (ret_req),
   .pc_load    (pc_load),
   .pc_target  (pc_target),
   .xcpt_taken (xcpt_taken),
   .cpsr       (cpsr)
);

// File: tb/xcpt_ctrl_tb.sv
`timescale 1ns/1ps
module xcpt_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_done = 1'b0, ret_req = 1'b0;
   logic        dabt_req = 1'b0, fiq_req = 1'b0, irq_req = 1'b0;
   logic        pabt_req = 1'b0, und_req = 1'b0, swi_req = 1'b0;
   logic [31:0] link_in = '0;
   logic        pc_load;
   logic [31:0] pc_target;
   logic [5:0]  xcpt_taken;
   logic [31:0] cpsr;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   bit drv_rst = 0;

   always #2.5 clk = ~clk;

   xcpt_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .ret_req(ret_req),
      .dabt_req(dabt_req), .fiq_req(fiq_req), .irq_req(irq_req),
      .pabt_req(pabt_req), .und_req(und_req), .swi_req(swi_req),
      .link_in(link_in), .pc_load(pc_load), .pc_target(pc_target),
      .xcpt_taken(xcpt_taken), .cpsr(cpsr)
   );

   // behavioural reference state
   logic [31:0] m_cpsr;
   logic [31:0] m_saved [int];
   logic [31:0] m_link  [int];
   bit          m_rpend;
   int          modes [$] = '{'h11, 'h12, 'h13, 'h17, 'h1B};

   function automatic bit privileged(input logic [4:0] m);
      foreach (modes[i]) if (int'(m) == modes[i]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic model_reset();
      m_cpsr  = 32'hD3;
      m_rpend = 1'b1;
      foreach (modes[i]) begin
         m_saved[modes[i]] = 32'h10;
         m_link[modes[i]]  = 32'h0;
      end
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one clock: drive, compare against the model, advance the model
   task automatic cyc(input bit d, r, da, fq, iq, pa, ud, sw,
                      input logic [31:0] lnk, input string tag);
      bit          e_load;
      logic [31:0] e_tgt, eff, nsr, ret_pc;
      logic [5:0]  e_taken;
      int          src, cm, tm;
      @(negedge clk);
      rst_n = drv_rst; insn_done = d; ret_req = r; dabt_req = da; fiq_req = fq;
      irq_req = iq; pabt_req = pa; und_req = ud; swi_req = sw; link_in = lnk;
      if (!rst_n) model_reset();
      #1;
      e_load = 0; e_tgt = 0; e_taken = 0;
      cm = int'(m_cpsr[4:0]);
      if (m_rpend) begin
         e_load = 1; e_tgt = 0;
         chk(cpsr == m_cpsr, tag, "cpsr", cpsr, m_cpsr);
         chk(pc_load == 1'b1, tag, "pc_load", 32'(pc_load), 32'd1);
         chk(pc_target == 0, tag, "pc_target", pc_target, 0);
         chk(xcpt_taken == 0, tag, "taken", 32'(xcpt_taken), 0);
         if (rst_n) m_rpend = 0;
         return;
      end
      chk(cpsr == m_cpsr, tag, "cpsr", cpsr, m_cpsr);
      src = -1;
      if (d) begin
         bit rok = r && privileged(m_cpsr[4:0]);
         eff    = rok ? m_saved[cm] : m_cpsr;
         ret_pc = rok ? m_link[cm] : 32'h0;
         if (da) src = 0;
         else if (fq && !eff[6]) src = 1;
         else if (iq && !eff[7]) src = 2;
         else if (pa) src = 3;
         else if (ud) src = 4;
         else if (sw) src = 5;
         if (src >= 0) begin
            case (src)
               0: begin tm = 'h17; e_tgt = 32'h10; end
               1: begin tm = 'h11; e_tgt = 32'h1C; end
               2: begin tm = 'h12; e_tgt = 32'h18; end
               3: begin tm = 'h17; e_tgt = 32'h0C; end
               4: begin tm = 'h1B; e_tgt = 32'h04; end
               default: begin tm = 'h13; e_tgt = 32'h08; end
            endcase
            e_load = 1; e_taken = 6'(1 << src);
            nsr = eff; nsr[4:0] = 5'(tm); nsr[5] = 0; nsr[7] = 1;
            if (src == 1) nsr[6] = 1;
            m_saved[tm] = eff;
            m_link[tm]  = rok ? ret_pc : lnk;
            m_cpsr = nsr;
         end else if (rok) begin
            e_load = 1; e_tgt = ret_pc; m_cpsr = eff;
         end
      end
      chk(pc_load == e_load, tag, "pc_load", 32'(pc_load), 32'(e_load));
      if (e_load) chk(pc_target == e_tgt, tag, "pc_target", pc_target, e_tgt);
      chk(xcpt_taken == e_taken, tag, "taken", 32'(xcpt_taken), 32'(e_taken));
   endtask

   task automatic peek(input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      chk(cpsr == exp, tag, "cpsr after edge", cpsr, exp);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      model_reset();
      // R1: reset held, requests ignored
      drv_rst = 0;
      cyc(1,1,1,1,1,1,1,0, 32'h44, "R1");
      cyc(1,0,1,0,1,0,0,1, 32'h44, "R1");
      drv_rst = 1;
      cyc(1,0,1,1,1,1,0,0, 32'h44, "R1");
      peek(32'hD3, "R1");
      // R11: no boundary, nothing happens
      cyc(0,1,1,1,1,1,1,0, 32'h55, "R11");
      // R6: both masks set in supervisor mode
      cyc(1,0,0,1,1,0,0,0, 32'h66, "R6");
      // R9: return from supervisor to user
      cyc(1,1,0,0,0,0,0,0, 32'h0, "R9");
      peek(32'h10, "R9");
      // R10: return in user mode does nothing
      cyc(1,1,0,0,0,0,0,0, 32'h0, "R10");
      peek(32'h10, "R10");
      // R2/R3/R4: normal beats prefetch abort and undefined
      cyc(1,0,0,0,1,1,1,0, 32'h100, "R2");
      peek(32'h92, "R4");
      // R5: fast interrupt from normal mode sets bit 6
      cyc(1,0,0,1,0,0,0,0, 32'h200, "R5");
      peek(32'hD1, "R5");
      // R7/R8: return from fast mode
      cyc(1,1,0,0,0,0,0,0, 32'h0, "R8");
      peek(32'h92, "R7");
      // R12: return and fast interrupt on one boundary
      cyc(1,1,0,1,0,0,0,0, 32'h300, "R12");
      peek(32'hD1, "R12");
      cyc(1,1,0,0,0,0,0,0, 32'h0, "R12");
      peek(32'h10, "R12");
      // R2: data abort outranks fast interrupt and software interrupt
      cyc(1,0,1,1,0,0,0,1, 32'h400, "R2");
      peek(32'h97, "R4");
      // R6: normal masked in abort mode
      cyc(1,0,0,0,1,0,0,0, 32'h0, "R6");
      // R3: undefined then software interrupt vectors
      cyc(1,0,0,0,0,0,1,0, 32'h500, "R3");
      peek(32'h9B, "R3");
      cyc(1,0,0,0,0,0,0,1, 32'h600, "R3");
      peek(32'h93, "R3");
      // R13: random traffic with a reset in the middle
      for (int n = 0; n < 3000; n++) begin
         bit ud, sw;
         ud = ($urandom % 7) == 0;
         sw = !ud && ($urandom % 7) == 0;
         drv_rst = !(n >= 1500 && n < 1503);
         cyc(($urandom % 10) < 7, ($urandom % 5) == 0, ($urandom % 9) == 0,
             ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 8) == 0,
             ud, sw, $urandom & 32'hFFFF_FFFC, "R13");
      end
      finish_run();
   end
endmodule